// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block carries out the four exclusive-access operations of a 32-bit core: load-exclusive, store-exclusive, clear-exclusive and get-exclusive. It holds a single reservation made of a word address and the data word that was read from that address. A later store-exclusive to the same address is done as an atomic compare-and-swap on a simple word memory port. The new data lands only if memory still holds the recorded word. No other bus agents are snooped. A changed value is the only thing that breaks the reservation.

The outcome of a store-exclusive is not returned in a separate destination. It is kept in a one-bit exclusive flag, which models the single status bit of an atomic control register. Each store-exclusive replaces the flag with its own outcome and returns the flag's previous value. Get-exclusive swaps the flag with bit 0 of an operand, which lets software read the outcome and preset the flag.

The core issues one request per cycle when `busy` is low. Each request produces exactly one response pulse.

Top module: `excl_monitor`

## Requirements
- R1: After reset no reservation is held and the exclusive flag is 0. A store-exclusive issued before any load-exclusive writes nothing to memory, and `busy`, `rsp_valid` and `mem_req` are low once reset is released.
- R2: A load-exclusive (`req_op`=0) to an aligned address reads the word over the memory port and returns it on `rsp_data` with `rsp_valid` two cycles after the accepting edge. It records that address and that word as the reservation.
- R3: A load-exclusive or store-exclusive whose address has bit 1 or bit 0 set gives a one-cycle response with `rsp_fault`=1 and `rsp_data`=0. It makes no memory access and changes neither the reservation nor the flag.
- R4: A store-exclusive (`req_op`=1) to an aligned address other than the reserved one responds in the next cycle and writes nothing. It returns the old flag in `rsp_data` bit 0, clears the flag to 0 and leaves the reservation in place.
- R5: A store-exclusive to the reserved address reads the word. When the word equals the recorded value, it writes the store data in the cycle after the read and sets the flag to 1. The response, carrying the old flag, comes two cycles after the accepting edge.
- R6: A store-exclusive to the reserved address whose memory word no longer equals the recorded value writes nothing and sets the flag to 0.
- R7: Every store-exclusive that matched the reserved address drops the reservation, whether or not the swap succeeded, so a further store-exclusive to that address fails.
- R8: A clear-exclusive (`req_op`=2) drops the reservation and responds in the next cycle with data 0.
- R9: A get-exclusive (`req_op`=3) responds in the next cycle with the old flag in bit 0 and loads `req_wdata` bit 0 into the flag.
- R10: A request is accepted only in a cycle with `busy` low. While a memory operation is in progress, `busy` is high and a request presented on the inputs has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load-ex, 1 store-ex, 2 clear-ex, 3 get-ex |
| req_addr | input | 32 | Byte address for load-ex and store-ex |
| req_wdata | input | 32 | Store data, or the flag operand (bit 0) for get-ex |
| busy | output | 1 | A memory operation is in progress and no request is accepted |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 32 | Loaded word, or the old flag in bit 0 |
| rsp_fault | output | 1 | Alignment fault on this response |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory word address (byte address) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read access |

## Verification
The bench sets up a compare-and-swap in which another agent has changed the reserved word between the load and the store. A design that compared only addresses would then overwrite that agent's data. The bench also checks that a failed swap drops the reservation, that an address-mismatched store leaves it in place, and that a misaligned store neither drops it nor touches memory. A monitor that confused these cases would let a later store succeed or fail wrongly. It presents a clear-exclusive while the block is busy. A design that accepted it would break the following store. It also exercises the flag exchange in both directions, which catches a result bit lost or returned after the update instead of before it.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_CLEAR = 2'd2,
    OP_GET   = 2'd3
  } excl_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_CMP  = 2'd2
  } excl_state_e;
endpackage

// File: rtl/excl_resv.sv
module excl_resv #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_en,
  input  logic [AW-1:0] rec_addr,
  input  logic [DW-1:0] rec_val,
  input  logic          inval_en,
  output logic [AW-1:0] resv_addr,
  output logic [DW-1:0] resv_val
);
  localparam logic [AW-1:0] NO_RESV = '1;

  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = rec_en | inval_en;
    addr_d  = rec_en ? rec_addr : NO_RESV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_addr <= NO_RESV;
    end else if (addr_en) begin
      resv_addr <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_val <= '0;
    end else if (rec_en) begin
      resv_val <= rec_val;
    end
  end

  AST_INVAL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !rec_en) |=> (resv_addr == NO_RESV)); // R8
endmodule

// File: rtl/excl_flag.sv
module excl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (wr_en) begin
      flag <= wr_val;
    end
  end
endmodule

// File: rtl/excl_seq.sv
module excl_seq
  import excl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-1:0] resv_addr,
  input  logic [DW-1:0] resv_val,
  input  logic          flag,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fault,
  output logic          rec_en,
  output logic [AW-1:0] rec_addr,
  output logic [DW-1:0] rec_val,
  output logic          inval_en,
  output logic          flag_we,
  output logic          flag_d
);
  localparam logic [DW-1:0] ZERO_W = '0;

  excl_state_e   state_q, state_d;
  logic          store_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  excl_op_e      op;
  logic          accept, misalign, is_mem, store_hit, go_mem, cmp_eq;
  logic          rsp_valid_d, rsp_fault_d;
  logic [DW-1:0] rsp_data_d;

  always_comb begin
    op        = excl_op_e'(req_op);
    busy      = (state_q != ST_IDLE);
    accept    = req_valid && !busy;
    misalign  = |req_addr[ALIGN-1:0];
    is_mem    = (op == OP_LOAD) || (op == OP_STORE);
    store_hit = (op == OP_STORE) && !misalign && (req_addr == resv_addr);
    go_mem    = accept && !misalign && ((op == OP_LOAD) || store_hit);
    cmp_eq    = (mem_rdata == resv_val);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go_mem) state_d = ST_READ;
      ST_READ: state_d = ST_CMP;
      ST_CMP:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = (state_q == ST_READ) || ((state_q == ST_CMP) && store_q && cmp_eq);
    mem_we    = (state_q == ST_CMP);
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    rec_en    = (state_q == ST_CMP) && !store_q;
    rec_addr  = addr_q;
    rec_val   = mem_rdata;
    inval_en  = (accept && (op == OP_CLEAR)) || ((state_q == ST_CMP) && store_q);
    flag_we   = ((state_q == ST_CMP) && store_q) ||
                (accept && ((op == OP_GET) ||
                            ((op == OP_STORE) && !misalign && !store_hit)));
    if (state_q == ST_CMP) flag_d = cmp_eq;
    else                   flag_d = (op == OP_GET) ? req_wdata[0] : 1'b0;
  end

  always_comb begin
    rsp_valid_d = (accept && !go_mem) || (state_q == ST_CMP);
    rsp_fault_d = accept && is_mem && misalign;
    rsp_data_d  = ZERO_W;
    if (state_q == ST_CMP) begin
      rsp_data_d = store_q ? {{(DW-1){1'b0}}, flag} : mem_rdata;
    end else if (!rsp_fault_d && ((op == OP_GET) || (op == OP_STORE))) begin
      rsp_data_d = {{(DW-1){1'b0}}, flag};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_valid_d;
      rsp_fault <= rsp_fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data <= '0;
    end else if (rsp_valid_d) begin
      rsp_data <= rsp_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (go_mem) begin
      store_q <= (op == OP_STORE);
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  AST_WRITE_ONLY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_rdata == resv_val)); // R5
  AST_ALIGNED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ALIGN-1:0] == '0)); // R3
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_mem && misalign) |=> (rsp_fault && !mem_req && !busy)); // R3
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(wdata_q))); // R10
  AST_INVALID_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((&resv_addr) && accept && (op == OP_STORE)) |=> !busy); // R7
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int ALIGN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fault,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic [1:0]    rst_sync;
  logic          rst_n_s;
  logic [AW-1:0] resv_addr, rec_addr;
  logic [DW-1:0] resv_val, rec_val;
  logic          rec_en, inval_en, flag, flag_we, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync[1];

  excl_seq #(.AW(AW), .DW(DW), .ALIGN(ALIGN)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .resv_addr(resv_addr), .resv_val(resv_val), .flag(flag), .mem_rdata(mem_rdata),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .rec_en(rec_en), .rec_addr(rec_addr), .rec_val(rec_val),
    .inval_en(inval_en), .flag_we(flag_we), .flag_d(flag_d)
  );

  excl_resv #(.AW(AW), .DW(DW)) u_resv (
    .clk(clk), .rst_n(rst_n_s), .rec_en(rec_en), .rec_addr(rec_addr),
    .rec_val(rec_val), .inval_en(inval_en), .resv_addr(resv_addr), .resv_val(resv_val)
  );

  excl_flag u_flag (
    .clk(clk), .rst_n(rst_n_s), .wr_en(flag_we), .wr_val(flag_d), .flag(flag)
  );

  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_fault |-> (rsp_valid && (rsp_data == '0))); // R3
  AST_RESULT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flag) |-> $past(flag_we)); // R9
endmodule

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, CL = 2'd2, GX = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy, rsp_valid, rsp_fault, mem_req, mem_we;
  logic [31:0] rsp_data, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int errors = 0, checks = 0, cyc = 0, due = -1, mem_acc = 0;
  bit started = 0, done = 0;
  string cur_tag = "R1";
  logic [31:0] exp_data = '0;
  bit exp_fault = 0;

  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic [31:0] ref_addr = '1, ref_val = '0;
  bit ref_flag = 0;

  excl_monitor uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      mem_acc <= mem_acc + 1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      bit ev;
      ev = (cyc == due);
      check(rsp_valid == ev, {cur_tag, " rsp_valid"}, 32'(rsp_valid), 32'(ev));
      if (ev && rsp_valid) begin
        check(rsp_data == exp_data, {cur_tag, " rsp_data"}, rsp_data, exp_data);
        check(rsp_fault == exp_fault, {cur_tag, " rsp_fault"}, 32'(rsp_fault), 32'(exp_fault));
      end
    end
  end

  task automatic do_op(logic [1:0] op, logic [31:0] a, logic [31:0] d, string tag);
    int lat;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    cur_tag = tag;
    lat = 0; exp_fault = 0; exp_data = '0;
    if ((op == LD || op == ST) && a[1:0] != 2'b00) begin
      exp_fault = 1;
    end else if (op == LD) begin
      exp_data = ref_mem[a[7:2]]; ref_addr = a; ref_val = exp_data; lat = 2;
    end else if (op == ST) begin
      exp_data = {31'd0, ref_flag};
      if (a != ref_addr) begin
        ref_flag = 0;
      end else begin
        ref_flag = (ref_mem[a[7:2]] == ref_val);
        if (ref_flag) ref_mem[a[7:2]] = d;
        ref_addr = '1; lat = 2;
      end
    end else if (op == CL) begin
      ref_addr = '1;
    end else begin
      exp_data = {31'd0, ref_flag}; ref_flag = d[0];
    end
    due = cyc + 1 + lat;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc <= due) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_mem(logic [31:0] a, string tag);
    check(mem[a[7:2]] == ref_mem[a[7:2]], tag, mem[a[7:2]], ref_mem[a[7:2]]);
  endtask

  task automatic other_write(logic [31:0] a, logic [31:0] d);
    mem[a[7:2]] = d; ref_mem[a[7:2]] = d;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int acc0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = (i * 32'h01010101) ^ 32'hA5;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy, "R1 busy after reset", 32'(busy), 0);
    check(!rsp_valid, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    check(!mem_req, "R1 mem_req after reset", 32'(mem_req), 0);
    started = 1;

    do_op(ST, 32'h10, 32'hDEAD0001, "R1 store without reservation");
    chk_mem(32'h10, "R1 no write without reservation");
    do_op(GX, 32'h0, 32'h1, "R9 get-ex flag 0 to 1");
    do_op(GX, 32'h0, 32'h0, "R9 get-ex flag 1 to 0");

    do_op(LD, 32'h20, 0, "R2 load-ex");
    do_op(ST, 32'h20, 32'hCAFE0020, "R5 store-ex success");
    chk_mem(32'h20, "R5 swap written");
    do_op(GX, 32'h0, 32'h0, "R5 flag set by success");
    do_op(ST, 32'h20, 32'h11112222, "R7 reservation dropped after success");
    chk_mem(32'h20, "R7 no write after success");

    do_op(LD, 32'h24, 0, "R2 load-ex second");
    other_write(32'h24, 32'h5A5A5A5A);
    do_op(ST, 32'h24, 32'h77777777, "R6 value changed");
    chk_mem(32'h24, "R6 no write on changed value");
    do_op(ST, 32'h24, 32'h88888888, "R7 reservation dropped after failed swap");
    chk_mem(32'h24, "R7 no write after failed swap");

    do_op(LD, 32'h30, 0, "R2 load-ex third");
    do_op(CL, 32'h0, 0, "R8 clear-ex");
    do_op(ST, 32'h30, 32'h33333333, "R8 store after clear");
    chk_mem(32'h30, "R8 no write after clear");

    do_op(LD, 32'h30, 0, "R2 load-ex again");
    acc0 = mem_acc;
    do_op(LD, 32'h31, 0, "R3 misaligned load");
    do_op(ST, 32'h32, 32'h44444444, "R3 misaligned store");
    check(mem_acc == acc0, "R3 no access on fault", mem_acc, acc0);
    do_op(ST, 32'h30, 32'h55555555, "R3 reservation kept across fault");
    chk_mem(32'h30, "R3 swap after fault");

    do_op(LD, 32'h40, 0, "R10 load-ex before busy request");
    do_op(LD, 32'h44, 0, "R10 load-ex while checking busy");
    @(negedge clk);
    req_valid = 1'b1; req_op = LD; req_addr = 32'h48; req_wdata = 0;
    cur_tag = "R10 second load";
    due = cyc + 3; exp_data = ref_mem[32'h48 >> 2]; exp_fault = 0;
    ref_addr = 32'h48; ref_val = exp_data;
    @(negedge clk);
    req_op = CL;
    check(busy, "R10 busy during read", 32'(busy), 1);
    @(negedge clk);
    check(busy, "R10 busy during compare", 32'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    do_op(ST, 32'h48, 32'h66666666, "R10 ignored clear");
    chk_mem(32'h48, "R10 swap after ignored clear");

    do_op(LD, 32'h50, 0, "R2 load-ex fourth");
    do_op(ST, 32'h54, 32'h99999999, "R4 address mismatch");
    chk_mem(32'h54, "R4 no write on mismatch");
    do_op(ST, 32'h50, 32'hABCDEF01, "R4 reservation kept after mismatch");
    chk_mem(32'h50, "R4 swap after mismatch");
    do_op(GX, 32'h0, 32'h0, "R9 final flag read");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule